// File: doc/BRIEF.md
# Cascaded Codec Serial Frame Controller

This block is the digital front end of the serial port of a codec that can sit in a chain of identical devices sharing one frame sync. It takes 16-bit frames from a serial data line, each marked by a one-cycle input frame-sync pulse, and decides per frame whether the word is configuration or DAC sample data. Configuration writes go out on a parallel register-write port. Sample data goes out on a DAC load strobe with a 16-bit word. The ADC sample is a parallel input word that is shifted out on a serial output with its own frame sync.

A three-state machine holds the operating mode. `ST_PROG` treats every frame as a control frame. `ST_DATA` treats every frame that belongs to this device as raw DAC data, and it can only be left through reset. `ST_MIXED` uses the frame MSB to tell control frames from 15-bit data. Writes to register address 0 move the machine between states: field value 01 goes to `ST_DATA`, 11 goes to `ST_MIXED` and 00 or 10 goes to `ST_PROG`. `ST_DATA` has no outgoing transition. Outside `ST_PROG`, the block counts frame syncs against a programmed device count, so that each device in a chain claims one slot per cycle of frames. Two diagnostic loopbacks exist. One feeds the ADC word into the DAC register. The other echoes the serial input, frame sync included, back out 16 clocks later.

Top module: `cascade_frame_ctl`

## Requirements
- R1: A frame is the 16 bits on `ser_in`, MSB first, sampled on the rising edge where `ser_fs_in` is high and on the 15 edges after it. The decision for that frame is visible as a one-cycle strobe (`dac_load` or `cfg_we`) one clock after the edge that samples the last bit. A control frame carries the register address in bits 14:12 and the register data in bits 7:0.
- R2: After reset the block is in `ST_PROG` with device count 1, both loopbacks off and all outputs low. In `ST_PROG` every frame is a control frame, whatever its MSB. A control write to address 0 programs the mode register: bit 0 selects data, bit 1 selects mixed, bit 2 enables digital loopback, bit 3 enables serial loopback, and bits 6:4 set the device count. A written count of 0 is taken as 1.
- R3: In `ST_DATA` every frame owned by this device loads all 16 bits unchanged into the DAC. `cfg_we` never rises again until reset, even for frames with MSB 1.
- R4: Outside `ST_PROG`, frame syncs are numbered 1, 2, … from the first one after the mode change, wrapping after the device count N. Only frame number N of each cycle is owned by this device. Frames it does not own produce no strobe and no serial output.
- R5: `ST_MIXED` can be entered straight from reset with a single control frame. In this mode an owned frame with MSB 0 loads `{bits 14:0, 0}` into the DAC, and an owned frame with MSB 1 is a control write.
- R6: When an owned frame's sync arrives outside `ST_PROG` and serial loopback is off, the ADC word is sent MSB first on `ser_out`. `ser_fs_out` pulses one clock after `ser_fs_in`, together with the MSB. In `ST_MIXED` the MSB is sent as 0.
- R7: With digital loopback on, every DAC load takes `adc_word` instead of the frame content.
- R8: With serial loopback on, `ser_out` and `ser_fs_out` repeat `ser_in` and `ser_fs_in` delayed by exactly 16 clocks, and the ADC word is not transmitted.
- R9: A write to address 0 can clear a loopback bit only while the block is in `ST_MIXED`. In `ST_PROG` the loopback bits can only be set.
- R10: `dac_load` and `cfg_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial data in |
| ser_fs_in | input | 1 | Input frame sync, high with the frame MSB |
| adc_word | input | 16 | Current ADC sample |
| dac_load | output | 1 | One-cycle DAC register load strobe |
| dac_word | output | 16 | DAC register value |
| cfg_we | output | 1 | One-cycle control register write strobe |
| cfg_addr | output | 3 | Control register address |
| cfg_data | output | 8 | Control register data |
| ser_out | output | 1 | Serial data out |
| ser_fs_out | output | 1 | Output frame sync |

## Verification
The assertions assume that input frame syncs are at least 16 clocks apart. This guarantees that a completed frame is never followed one cycle later by another completion. They also assume that the loopback enables change only at frame completions. The bench always drives a full 16-bit frame after each sync and leaves idle cycles between frames, so both assumptions hold. The serial-loopback scenario spaces its frames far enough apart that echoed syncs never overlap a new frame.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
    localparam int FRAME_W  = 16;
    localparam int ADDR_W   = 3;
    localparam int CDATA_W  = 8;
    localparam int DCNT_W   = 3;
    // mode register (address 0) field positions
    localparam int F_DATA   = 0;
    localparam int F_MIXED  = 1;
    localparam int F_DLB    = 2;
    localparam int F_SLB    = 3;
    localparam int F_DCNT   = 4;

    typedef enum logic [1:0] {
        ST_PROG  = 2'd0,
        ST_DATA  = 2'd1,
        ST_MIXED = 2'd2
    } mode_e;
endpackage

// File: rtl/cfc_rx.sv
module cfc_rx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdi,
    input  logic         fs,
    output logic         frame_vld,
    output logic [W-1:0] frame
);
    localparam int CW = $clog2(W) + 1;

    logic [W-1:0]  sh;
    logic [CW-1:0] bitc;
    logic          busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh        <= '0;
            bitc      <= '0;
            busy      <= 1'b0;
            frame_vld <= 1'b0;
        end else begin
            frame_vld <= 1'b0;
            if (fs) begin
                sh   <= {{(W-1){1'b0}}, sdi};
                bitc <= CW'(1);
                busy <= 1'b1;
            end else if (busy) begin
                sh   <= {sh[W-2:0], sdi};
                bitc <= bitc + 1'b1;
                if (bitc == CW'(W-1)) begin
                    busy      <= 1'b0;
                    frame_vld <= 1'b1;
                end
            end
        end
    end

    assign frame = sh;

    // R1
    frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);
endmodule

// File: rtl/cfc_tx.sv
module cfc_tx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] word,
    input  logic         clr_msb,
    input  logic         slb,
    input  logic         sdi,
    input  logic         fs,
    output logic         sdo,
    output logic         sdofs
);
    logic [W-1:0] sh;
    logic         ofs;
    logic [W-1:0] dly_d;
    logic [W-1:0] dly_f;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            ofs   <= 1'b0;
            dly_d <= '0;
            dly_f <= '0;
        end else begin
            sh    <= start ? word : {sh[W-2:0], 1'b0};
            ofs   <= start;
            dly_d <= {dly_d[W-2:0], sdi};
            dly_f <= {dly_f[W-2:0], fs};
        end
    end

    assign sdo   = slb ? dly_d[W-1] : sh[W-1];
    assign sdofs = slb ? dly_f[W-1] : ofs;

    // R6
    adc_msb_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && clr_msb) |=> (slb || (sdofs && !sdo)));
endmodule

// File: rtl/cfc_ctrl.sv
module cfc_ctrl
    import cfc_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fs,
    input  logic               frame_vld,
    input  logic [W-1:0]       frame,
    input  logic [W-1:0]       adc_word,
    output logic               dac_load,
    output logic [W-1:0]       dac_word,
    output logic               ctl_we,
    output logic [ADDR_W-1:0]  ctl_addr,
    output logic [CDATA_W-1:0] ctl_data,
    output logic               tx_start,
    output logic [W-1:0]       tx_word,
    output logic               tx_clr_msb,
    output logic               slb
);
    mode_e              st, st_n;
    logic [DCNT_W-1:0]  dcnt, dcnt_n;
    logic [DCNT_W-1:0]  idx;
    logic               mine;
    logic               dlb, dlb_n, slb_n;

    logic               take, is_ctl, is_dat, wr_mode, mine_now;
    logic [ADDR_W-1:0]  f_addr;
    logic [CDATA_W-1:0] f_data;
    logic [DCNT_W-1:0]  f_cnt;
    logic [W-1:0]       dac_n;
    logic               unused_bits;

    assign f_addr      = frame[W-2 -: ADDR_W];
    assign f_data      = frame[CDATA_W-1:0];
    assign f_cnt       = f_data[F_DCNT +: DCNT_W];
    assign unused_bits = ^frame[W-2-ADDR_W:CDATA_W];
    assign mine_now    = (st != ST_PROG) && (idx == dcnt);

    always_comb begin
        take    = frame_vld && mine;
        is_ctl  = take && ((st == ST_PROG) || (st == ST_MIXED && frame[W-1]));
        is_dat  = take && ((st == ST_DATA) || (st == ST_MIXED && !frame[W-1]));
        wr_mode = is_ctl && (f_addr == '0);
        st_n    = st;
        dcnt_n  = dcnt;
        dlb_n   = dlb;
        slb_n   = slb;
        if (wr_mode) begin
            dcnt_n = (f_cnt == '0) ? DCNT_W'(1) : f_cnt;
            if (st == ST_MIXED) begin
                dlb_n = f_data[F_DLB];
                slb_n = f_data[F_SLB];
            end else begin
                dlb_n = dlb | f_data[F_DLB];
                slb_n = slb | f_data[F_SLB];
            end
            unique case ({f_data[F_MIXED], f_data[F_DATA]})
                2'b01:   st_n = ST_DATA;
                2'b11:   st_n = ST_MIXED;
                default: st_n = ST_PROG;
            endcase
        end
        if (dlb)
            dac_n = adc_word;
        else if (st == ST_MIXED)
            dac_n = {frame[W-2:0], 1'b0};
        else
            dac_n = frame;
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_PROG;
            dcnt <= DCNT_W'(1);
            idx  <= DCNT_W'(1);
            mine <= 1'b1;
            dlb  <= 1'b0;
            slb  <= 1'b0;
        end else begin
            st   <= st_n;
            dcnt <= dcnt_n;
            dlb  <= dlb_n;
            slb  <= slb_n;
            if (st == ST_PROG) begin
                idx <= DCNT_W'(1);
                if (fs) mine <= 1'b1;
            end else if (fs) begin
                mine <= (idx == dcnt);
                idx  <= (idx >= dcnt) ? DCNT_W'(1) : idx + 1'b1;
            end
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_load <= 1'b0;
            dac_word <= '0;
            ctl_we   <= 1'b0;
            ctl_addr <= '0;
            ctl_data <= '0;
        end else begin
            dac_load <= is_dat;
            ctl_we   <= is_ctl;
            if (is_dat) dac_word <= dac_n;
            if (is_ctl) begin
                ctl_addr <= f_addr;
                ctl_data <= f_data;
            end
        end
    end

    assign tx_start   = fs && mine_now && !slb;
    assign tx_clr_msb = (st == ST_MIXED);
    assign tx_word    = tx_clr_msb ? {1'b0, adc_word[W-2:0]} : adc_word;

    // R3
    data_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA) |=> (st == ST_DATA && !ctl_we));
    // R9
    loop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(dlb) && !dlb) || ($past(slb) && !slb)) |-> ($past(st) == ST_MIXED));
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dac_load, ctl_we}));
    // R5
    mix_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_load && $past(st) == ST_MIXED && !$past(dlb)) |-> !dac_word[0]);
endmodule

// File: rtl/cascade_frame_ctl.sv
module cascade_frame_ctl
    import cfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_in,
    input  logic               ser_fs_in,
    input  logic [FRAME_W-1:0] adc_word,
    output logic               dac_load,
    output logic [FRAME_W-1:0] dac_word,
    output logic               cfg_we,
    output logic [ADDR_W-1:0]  cfg_addr,
    output logic [CDATA_W-1:0] cfg_data,
    output logic               ser_out,
    output logic               ser_fs_out
);
    logic               frame_vld;
    logic [FRAME_W-1:0] frame;
    logic               tx_start, tx_clr_msb, slb;
    logic [FRAME_W-1:0] tx_word;

    cfc_rx #(.W(FRAME_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sdi(ser_in), .fs(ser_fs_in),
        .frame_vld(frame_vld), .frame(frame)
    );

    cfc_ctrl #(.W(FRAME_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fs(ser_fs_in),
        .frame_vld(frame_vld), .frame(frame), .adc_word(adc_word),
        .dac_load(dac_load), .dac_word(dac_word),
        .ctl_we(cfg_we), .ctl_addr(cfg_addr), .ctl_data(cfg_data),
        .tx_start(tx_start), .tx_word(tx_word), .tx_clr_msb(tx_clr_msb),
        .slb(slb)
    );

    cfc_tx #(.W(FRAME_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .word(tx_word),
        .clr_msb(tx_clr_msb), .slb(slb), .sdi(ser_in), .fs(ser_fs_in),
        .sdo(ser_out), .sdofs(ser_fs_out)
    );
endmodule

// File: tb/test_cascade_frame_ctl.sv
module test_cascade_frame_ctl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_in = 1'b0;
    logic        ser_fs_in = 1'b0;
    logic [15:0] adc_word = '0;
    logic        dac_load;
    logic [15:0] dac_word;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [7:0]  cfg_data;
    logic        ser_out;
    logic        ser_fs_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic        g_load, g_we, g_ofs, e_fs;
    logic [15:0] g_dac, g_out, echo;
    logic [2:0]  g_addr;
    logic [7:0]  g_data;

    cascade_frame_ctl i_cascade_frame_ctl (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_fs_in(ser_fs_in),
        .adc_word(adc_word), .dac_load(dac_load), .dac_word(dac_word),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .ser_out(ser_out), .ser_fs_out(ser_fs_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ctlw(input int a, input int d);
        return {1'b1, 3'(a), 4'h0, 8'(d)};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; ser_in = 0; ser_fs_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic send(input logic [15:0] w);
        g_ofs = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (i >= 1) g_out[16-i] = ser_out;
            if (i == 1) g_ofs = ser_fs_out;
            ser_fs_in = (i == 0);
            ser_in    = w[15-i];
        end
        @(negedge clk);
        g_out[0] = ser_out;
        e_fs     = ser_fs_out;
        echo[15] = ser_out;
        ser_fs_in = 0; ser_in = 0;
        @(negedge clk);
        g_load = dac_load; g_dac = dac_word;
        g_we = cfg_we; g_addr = cfg_addr; g_data = cfg_data;
        echo[14] = ser_out;
    endtask

    task automatic expect_ctl(input string req, input int a, input int d);
        chk(req, "cfg_we", 32'(g_we), 32'd1);
        chk(req, "cfg_addr", 32'(g_addr), 32'(a));
        chk(req, "cfg_data", 32'(g_data), 32'(d & 8'hFF));
        chk(req, "dac_load", 32'(g_load), 32'd0);
    endtask

    task automatic expect_dat(input string req, input logic [15:0] v);
        chk(req, "dac_load", 32'(g_load), 32'd1);
        chk(req, "dac_word", 32'(g_dac), 32'(v));
        chk(req, "cfg_we", 32'(g_we), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2 reset state
        @(negedge clk);
        chk("R2", "reset dac_load", 32'(dac_load), 0);
        chk("R2", "reset cfg_we", 32'(cfg_we), 0);
        chk("R2", "reset ser_fs_out", 32'(ser_fs_out), 0);
        chk("R2", "reset ser_out", 32'(ser_out), 0);

        // R1 program-mode writes to every non-mode address
        for (int a = 1; a < 8; a++) begin
            send(ctlw(a, a * 17 + 3));
            expect_ctl("R1", a, a * 17 + 3);
            chk("R6", "no adc out in prog", 32'(g_ofs), 0);
        end
        // R2 MSB 0 frame is still control in program mode
        send({1'b0, 3'd5, 4'h0, 8'h3C});
        expect_ctl("R2", 5, 8'h3C);

        // R3 R4 plain data mode with device counts 1..4
        for (int n = 1; n <= 4; n++) begin
            do_reset();
            send(ctlw(0, (n << 4) | 1));
            expect_ctl("R2", 0, (n << 4) | 1);
            for (int f = 1; f <= 2 * n; f++) begin
                logic [15:0] w;
                w = 16'h9000 + 16'(n * 256 + f);
                adc_word = 16'hC000 | 16'(f * 7 + n);
                send(w);
                chk("R3", "no cfg write in data mode", 32'(g_we), 0);
                if (f % n == 0) begin
                    chk("R4", "own slot load", 32'(g_load), 1);
                    chk("R3", "full word", 32'(g_dac), 32'(w));
                    chk("R6", "adc sync", 32'(g_ofs), 1);
                    chk("R6", "adc bits", 32'(g_out), 32'(adc_word));
                end else begin
                    chk("R4", "foreign slot no load", 32'(g_load), 0);
                    chk("R4", "foreign slot no tx", 32'(g_ofs), 0);
                end
            end
        end

        // R2 device count 0 acts as 1
        do_reset();
        send(ctlw(0, 8'h01));
        for (int f = 0; f < 3; f++) begin
            send(16'h0100 + 16'(f));
            expect_dat("R2", 16'h0100 + 16'(f));
        end

        // R5 mixed mode straight from reset
        do_reset();
        send(ctlw(0, 8'h13));
        expect_ctl("R5", 0, 8'h13);
        for (int k = 0; k < 8; k++) begin
            logic [15:0] v;
            v = 16'((k * 16'h1357 + 16'h00A1) & 16'h7FFF);
            adc_word = 16'hFFFF ^ 16'(k * 16'h0911);
            send(v);
            expect_dat("R5", 16'((v << 1) & 16'hFFFF));
            chk("R6", "mixed adc sync", 32'(g_ofs), 1);
            chk("R6", "mixed adc msb cleared", 32'(g_out), 32'(adc_word & 16'h7FFF));
        end
        send(ctlw(6, 8'hA5));
        expect_ctl("R5", 6, 8'hA5);

        // R4 slot counting in mixed mode, count 2
        send(ctlw(0, 8'h23));
        send(16'h0011);
        chk("R4", "mixed slot1 ignored", 32'(g_load), 0);
        send(16'h0022);
        expect_dat("R4", 16'h0044);
        send(ctlw(4, 8'h77));
        chk("R4", "foreign ctl ignored", 32'(g_we), 0);
        send(ctlw(0, 8'h13));
        expect_ctl("R4", 0, 8'h13);

        // R7 digital loopback, R9 cleared in mixed
        send(ctlw(0, 8'h17));
        adc_word = 16'h1234;
        send(16'h0111);
        expect_dat("R7", 16'h1234);
        send(ctlw(0, 8'h13));
        send(16'h0111);
        expect_dat("R9", 16'h0222);

        // R9 sticky in program mode
        do_reset();
        send(ctlw(0, 8'h04));
        send(ctlw(0, 8'h00));
        send(ctlw(0, 8'h13));
        adc_word = 16'h4321;
        send(16'h0005);
        expect_dat("R9", 16'h4321);

        // R7 loopback in plain data mode loads full adc word
        do_reset();
        send(ctlw(0, 8'h15));
        adc_word = 16'hABCD;
        send(16'h0F0F);
        expect_dat("R7", 16'hABCD);

        // R8 serial loopback
        do_reset();
        send(ctlw(0, 8'h1B));
        adc_word = 16'h5555;
        send(16'h35A7);
        for (int k = 13; k >= 0; k--) begin
            @(negedge clk);
            echo[k] = ser_out;
        end
        chk("R8", "echo sync", 32'(e_fs), 1);
        chk("R8", "echo word", 32'(echo), 32'h35A7);
        chk("R8", "adc suppressed", 32'(g_ofs), 0);
        repeat (20) @(negedge clk);
        send(ctlw(0, 8'h13));
        repeat (20) @(negedge clk);
        send(16'h0001);
        chk("R9", "slb cleared adc sync", 32'(g_ofs), 1);
        chk("R9", "slb cleared adc bits", 32'(g_out), 32'h5555);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule